// File: doc/BRIEF.md
# Last-Level Cache Line State Controller

This block keeps the per-line coherence state (I, S, E, M) of a last-level cache and decides, for each request, whether memory must be fetched. Every request picks its own mode. In exclusive mode the cache holds a line only after an inner level writes it back, and a demand read gives the line up again. In non-inclusive mode the usual MESI rules apply. An inner-copy flag says that an inner cache already holds the line, so the memory fetch can be skipped. A prefetch flag keeps an exclusive-mode line resident after it is read.

A request gives a line index, or a miss marker when no line is allocated, together with an access type, the two flags and a request timestamp. One cycle later the block returns the line's resulting state, whether a memory fetch was issued, and the response timestamp. A fetch adds the memory latency, taken from an input, plus a fixed round-trip latency set by a parameter. Four counters record the writebacks seen, split by mode and by clean or dirty. Tag lookup, the data array and memory are outside the block. In non-inclusive mode a request with the miss marker is ignored.

Top module: `llc_line_ctrl`

## Requirements
- R1: After reset every line is in I (state code 0), `resp_valid` is 0 and all four writeback counters are 0. State codes are I=0, S=1, E=2, M=3. Access type codes are GETS=0, GETX=1, PUTS=2, PUTX=3. `req_excl`=1 selects exclusive mode.
- R2: A request accepted on one clock edge gives `resp_valid`=1 after the next edge, and `resp_valid` is 0 after an edge with no request. `resp_cycle` equals `req_cycle` plus `mem_lat`+`RTT_LAT` when `resp_fetch`=1, and equals `req_cycle` otherwise. The addition is modulo 2^CYCLE_W.
- R3: In exclusive mode, a GETS or GETX carrying the miss marker fetches only when inner-copy is clear. It changes no line state and reports state I.
- R4: In exclusive mode with inner-copy clear, a PUTS installs the line in E and a PUTX installs it in M. With inner-copy set, either one leaves the state unchanged and no fetch is made.
- R5: In exclusive mode with a line index, a GETS fetches only when the line is in I and inner-copy is clear. A GETX fetches only when the line is in I or S and inner-copy is clear.
- R6: In exclusive mode, a GETS or GETX with a line index leaves the line in I. With the prefetch flag set, it leaves the line in E instead.
- R7: In non-inclusive mode, a GETS on a line in I moves it to S when inner-copy is set, with no fetch and no added latency. When inner-copy is clear, it fetches and moves the line to E. A GETS on any other state changes nothing.
- R8: In non-inclusive mode, a GETX always leaves the line in M. It fetches only when the line was in I or S and inner-copy is clear.
- R9: In non-inclusive mode, a PUTX turns E into M and leaves other states unchanged. A PUTS leaves the state unchanged. Neither one fetches. A request with the miss marker changes no state and does not fetch.
- R10: Each PUTS or PUTX request increments exactly one of four counters: exclusive clean, exclusive dirty, non-inclusive clean or non-inclusive dirty. Other requests leave all four unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_excl | input | 1 | 1 = exclusive mode, 0 = non-inclusive |
| req_type | input | 2 | Access type code |
| req_miss | input | 1 | No line allocated (miss marker) |
| req_line | input | LINE_W | Line index |
| req_inner | input | 1 | Inner level holds a copy |
| req_prefetch | input | 1 | Request is a prefetch |
| req_cycle | input | CYCLE_W | Request timestamp |
| mem_lat | input | LAT_W | Memory latency for a fetch |
| resp_valid | output | 1 | Response present |
| resp_fetch | output | 1 | A memory fetch was issued |
| resp_state | output | 2 | Line state after the request |
| resp_cycle | output | CYCLE_W | Response timestamp |
| wb_excl_clean | output | CNT_W | Exclusive-mode PUTS count |
| wb_excl_dirty | output | CNT_W | Exclusive-mode PUTX count |
| wb_ninc_clean | output | CNT_W | Non-inclusive PUTS count |
| wb_ninc_dirty | output | CNT_W | Non-inclusive PUTX count |

## Verification
Directed sequences drive each line from I through every state in both modes. Each reaching of a state is followed by a read that either fetches or skips the fetch. This separates the rules for state S and state I on GETX from the rule for GETS, and separates the effect of the inner-copy flag from that of the prefetch flag. A non-inclusive PUTS serves as a probe because it reveals the state without changing it. Back-to-back requests to the same line check that each request sees the state written by the one before it. A long random stream, which mixes both modes, the miss marker, both flags and varying timestamps, is compared against a behavioural model on every response. This stream covers the combinations that the directed sequences miss.

// File: rtl/llc_line_pkg.sv
package llc_line_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {AC_GETS = 2'd0, AC_GETX = 2'd1, AC_PUTS = 2'd2, AC_PUTX = 2'd3} acc_e;
  localparam int unsigned NUM_WB_CNT = 4;
endpackage

// File: rtl/llc_line_decide.sv
module llc_line_decide
  import llc_line_pkg::*;
(
  input  logic     excl,
  input  acc_e     acc,
  input  logic     miss,
  input  logic     inner,
  input  logic     prefetch,
  input  line_st_e cur,
  output logic     fetch,
  output logic     wr_en,
  output line_st_e nxt
);
  always_comb begin
    fetch = 1'b0;
    wr_en = 1'b0;
    nxt   = cur;
    if (miss) begin
      nxt = ST_I;
      if (excl && (acc == AC_GETS || acc == AC_GETX)) fetch = !inner;
    end else if (excl) begin
      unique case (acc)
        AC_PUTS: begin wr_en = !inner; if (!inner) nxt = ST_E; end
        AC_PUTX: begin wr_en = !inner; if (!inner) nxt = ST_M; end
        AC_GETS: begin
          fetch = (cur == ST_I) && !inner;
          wr_en = 1'b1;
          nxt   = prefetch ? ST_E : ST_I;
        end
        default: begin
          fetch = (cur == ST_I || cur == ST_S) && !inner;
          wr_en = 1'b1;
          nxt   = prefetch ? ST_E : ST_I;
        end
      endcase
    end else begin
      wr_en = 1'b1;
      unique case (acc)
        AC_PUTS: nxt = cur;
        AC_PUTX: nxt = (cur == ST_E) ? ST_M : cur;
        AC_GETS: begin
          if (cur == ST_I) begin
            fetch = !inner;
            nxt   = inner ? ST_S : ST_E;
          end
        end
        default: begin
          fetch = (cur == ST_I || cur == ST_S) && !inner;
          nxt   = ST_M;
        end
      endcase
    end
  end
endmodule

// File: rtl/llc_state_store.sv
module llc_state_store
  import llc_line_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_idx,
  input  line_st_e          wr_st,
  input  logic [LINE_W-1:0] rd_idx,
  output line_st_e          rd_st
);
  line_st_e st_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic     en;
    line_st_e d;
    always_comb begin
      en = wr_en && (wr_idx == LINE_W'(g));
      d  = en ? wr_st : st_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  st_q[g] <= ST_I;
      else if (en) st_q[g] <= d;
    end
  end

  always_comb begin
    rd_st = ST_I;
    for (int i = 0; i < NUM_LINES; i++)
      if (rd_idx == LINE_W'(i)) rd_st = st_q[i];
  end
endmodule

// File: rtl/llc_wb_counter.sv
module llc_wb_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  always_comb cnt_d = cnt_q + CNT_W'(1);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end
  assign count = cnt_q;

  a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/llc_line_ctrl.sv
module llc_line_ctrl
  import llc_line_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned CYCLE_W   = 32,
  parameter int unsigned LAT_W     = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RTT_LAT   = 6,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_excl,
  input  logic [1:0]         req_type,
  input  logic               req_miss,
  input  logic [LINE_W-1:0]  req_line,
  input  logic               req_inner,
  input  logic               req_prefetch,
  input  logic [CYCLE_W-1:0] req_cycle,
  input  logic [LAT_W-1:0]   mem_lat,
  output logic               resp_valid,
  output logic               resp_fetch,
  output logic [1:0]         resp_state,
  output logic [CYCLE_W-1:0] resp_cycle,
  output logic [CNT_W-1:0]   wb_excl_clean,
  output logic [CNT_W-1:0]   wb_excl_dirty,
  output logic [CNT_W-1:0]   wb_ninc_clean,
  output logic [CNT_W-1:0]   wb_ninc_dirty
);
  acc_e     acc;
  line_st_e cur_st, nxt_st;
  logic     fetch, wr_en;
  logic [CYCLE_W-1:0] cyc_d;
  logic [NUM_WB_CNT-1:0] wb_inc;
  logic [CNT_W-1:0] wb_cnt [NUM_WB_CNT];

  assign acc = acc_e'(req_type);

  llc_state_store #(.NUM_LINES(NUM_LINES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(req_valid && wr_en), .wr_idx(req_line), .wr_st(nxt_st),
    .rd_idx(req_line), .rd_st(cur_st)
  );

  llc_line_decide u_decide (
    .excl(req_excl), .acc(acc), .miss(req_miss), .inner(req_inner),
    .prefetch(req_prefetch), .cur(cur_st),
    .fetch(fetch), .wr_en(wr_en), .nxt(nxt_st)
  );

  always_comb begin
    cyc_d = req_cycle;
    if (fetch) cyc_d = req_cycle + CYCLE_W'(mem_lat) + CYCLE_W'(RTT_LAT);
    wb_inc[0] = req_valid &&  req_excl && (acc == AC_PUTS);
    wb_inc[1] = req_valid &&  req_excl && (acc == AC_PUTX);
    wb_inc[2] = req_valid && !req_excl && (acc == AC_PUTS);
    wb_inc[3] = req_valid && !req_excl && (acc == AC_PUTX);
  end

  for (genvar k = 0; k < NUM_WB_CNT; k++) begin : g_cnt
    llc_wb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(wb_inc[k]), .count(wb_cnt[k])
    );
  end
  assign wb_excl_clean = wb_cnt[0];
  assign wb_excl_dirty = wb_cnt[1];
  assign wb_ninc_clean = wb_cnt[2];
  assign wb_ninc_dirty = wb_cnt[3];

  logic               vld_q, fetch_q;
  line_st_e           st_q;
  logic [CYCLE_W-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      st_q    <= ST_I;
      cyc_q   <= '0;
    end else if (req_valid) begin
      fetch_q <= fetch;
      st_q    <= nxt_st;
      cyc_q   <= cyc_d;
    end
  end

  assign resp_valid = vld_q;
  assign resp_fetch = fetch_q;
  assign resp_state = st_q;
  assign resp_cycle = cyc_q;

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  a_r2_nofetch_time: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fetch) |-> resp_cycle == $past(req_cycle));
  a_r3_miss_no_state: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(req_miss)) |-> resp_state == 2'd0);
  a_r3_inner_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(req_inner)) |-> !resp_fetch);
  a_r6_excl_get_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(req_excl && !req_miss && !req_type[1] && !req_prefetch))
      |-> resp_state == 2'd0);
  a_r8_getx_to_m: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(!req_excl && !req_miss && req_type == 2'd1)) |-> resp_state == 2'd3);
  a_r9_put_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(req_type[1])) |-> !resp_fetch);
endmodule

// File: tb/llc_line_ctrl_tb.sv
`timescale 1ns/1ps
module llc_line_ctrl_tb;
  localparam int NL = 16;
  localparam int RTT = 6;
  localparam logic [7:0] MLAT = 8'd20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_excl = 1'b0, req_miss = 1'b0, req_inner = 1'b0, req_prefetch = 1'b0;
  logic [1:0] req_type = 2'd0;
  logic [3:0] req_line = 4'd0;
  logic [31:0] req_cycle = 32'd0;
  logic [7:0] mem_lat = MLAT;
  logic resp_valid, resp_fetch;
  logic [1:0] resp_state;
  logic [31:0] resp_cycle;
  logic [15:0] wb_excl_clean, wb_excl_dirty, wb_ninc_clean, wb_ninc_dirty;

  always #2 clk = ~clk;

  llc_line_ctrl #(.NUM_LINES(NL), .RTT_LAT(RTT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_excl(req_excl),
    .req_type(req_type), .req_miss(req_miss), .req_line(req_line),
    .req_inner(req_inner), .req_prefetch(req_prefetch), .req_cycle(req_cycle),
    .mem_lat(mem_lat), .resp_valid(resp_valid), .resp_fetch(resp_fetch),
    .resp_state(resp_state), .resp_cycle(resp_cycle),
    .wb_excl_clean(wb_excl_clean), .wb_excl_dirty(wb_excl_dirty),
    .wb_ninc_clean(wb_ninc_clean), .wb_ninc_dirty(wb_ninc_dirty)
  );

  int checks = 0, fails = 0;
  int mst [NL];
  int cnt [4];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input bit ex, input int ty, input bit miss, input int line,
                      input bit inn, input bit pf, input string req);
    int cur, nst, k;
    bit f;
    logic [31:0] cyc, ecyc;
    cur = miss ? 0 : mst[line];
    nst = cur; f = 0;
    cyc = $urandom;
    if (miss) begin
      nst = 0;
      if (ex && ty < 2) f = !inn;
    end else if (ex) begin
      if (ty == 2) begin if (!inn) nst = 2; end
      else if (ty == 3) begin if (!inn) nst = 3; end
      else begin
        if (ty == 0) f = (cur == 0) && !inn;
        else f = (cur <= 1) && !inn;
        nst = pf ? 2 : 0;
      end
    end else begin
      if (ty == 3 && cur == 2) nst = 3;
      if (ty == 0 && cur == 0) begin f = !inn; nst = inn ? 1 : 2; end
      if (ty == 1) begin f = (cur <= 1) && !inn; nst = 3; end
    end
    if (!miss) mst[line] = nst;
    if (ty >= 2) begin k = (ex ? 0 : 2) + (ty - 2); cnt[k]++; end
    ecyc = f ? cyc + 32'(MLAT) + 32'(RTT) : cyc;
    @(negedge clk);
    req_valid = 1'b1; req_excl = ex; req_type = 2'(ty); req_miss = miss;
    req_line = 4'(line); req_inner = inn; req_prefetch = pf; req_cycle = cyc;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(req, "valid", resp_valid, 1);
    chk(req, "fetch", resp_fetch, f);
    chk(req, "state", resp_state, nst);
    chk(req, "cycle", resp_cycle, ecyc);
    chk("R10", "excl clean", wb_excl_clean, cnt[0]);
    chk("R10", "excl dirty", wb_excl_dirty, cnt[1]);
    chk("R10", "ninc clean", wb_ninc_clean, cnt[2]);
    chk("R10", "ninc dirty", wb_ninc_dirty, cnt[3]);
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R2", "idle valid", resp_valid, 0);
  endtask

  localparam int GS = 0, GX = 1, PS = 2, PX = 3;

  initial begin
    for (int i = 0; i < NL; i++) mst[i] = 0;
    for (int i = 0; i < 4; i++) cnt[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset valid", resp_valid, 0);
    chk("R1", "reset cnt", wb_excl_clean + wb_excl_dirty + wb_ninc_clean + wb_ninc_dirty, 0);
    @(negedge clk); rst_n = 1'b1;
    idle();
    for (int i = 0; i < 4; i++) send(0, PS, 0, i, 0, 0, "R1");
    // R3 exclusive misses
    send(1, GS, 1, 0, 0, 0, "R3");
    send(1, GX, 1, 0, 1, 0, "R3");
    send(0, PS, 0, 0, 0, 0, "R3");
    // R4 exclusive installs
    send(1, PS, 0, 1, 0, 0, "R4");
    send(1, PX, 0, 2, 0, 0, "R4");
    send(1, PS, 0, 2, 1, 0, "R4");
    send(1, PX, 0, 1, 1, 0, "R4");
    // R5/R6 exclusive reads
    send(1, GS, 0, 1, 0, 0, "R5");
    send(1, GS, 0, 1, 0, 1, "R5");
    send(1, GS, 0, 1, 0, 0, "R6");
    send(1, GX, 0, 3, 1, 1, "R6");
    send(1, GX, 0, 3, 0, 0, "R5");
    send(0, GS, 0, 4, 1, 0, "R7");
    send(1, GX, 0, 4, 0, 1, "R5");
    send(1, GS, 0, 4, 0, 0, "R6");
    // R7 non-inclusive reads
    send(0, GS, 0, 5, 1, 0, "R7");
    send(0, GS, 0, 5, 0, 0, "R7");
    send(0, GS, 0, 6, 0, 0, "R7");
    // R8 non-inclusive GETX
    send(0, GX, 0, 5, 1, 0, "R8");
    send(0, GS, 0, 7, 1, 0, "R8");
    send(0, GX, 0, 7, 0, 0, "R8");
    send(0, GX, 0, 6, 0, 0, "R8");
    send(0, GX, 0, 8, 0, 0, "R8");
    // R9 non-inclusive puts
    send(0, GS, 0, 9, 0, 0, "R9");
    send(0, PS, 0, 9, 0, 0, "R9");
    send(0, PX, 0, 9, 0, 0, "R9");
    send(0, PX, 0, 10, 0, 0, "R9");
    send(0, GX, 0, 9, 0, 1, "R9");
    send(0, GS, 1, 9, 0, 0, "R9");
    send(0, PS, 0, 9, 0, 0, "R9");
    idle();
    // random mix
    for (int n = 0; n < 600; n++) begin
      bit ex, ms;
      int ty;
      ex = $urandom_range(0, 1);
      ty = $urandom_range(0, 3);
      ms = ($urandom_range(0, 7) == 0);
      if (ex && ms && ty >= 2) ms = 0;
      send(ex, ty, ms, $urandom_range(0, NL - 1), $urandom_range(0, 1),
           $urandom_range(0, 1), "R2");
      if ($urandom_range(0, 9) == 0) idle();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule